// File: doc/BRIEF.md
# Drum Computer Instruction Sequencer

This block fetches, decodes and carries out one 32-bit instruction at a time for a small accumulator machine whose store is a rotating drum. It holds three architectural registers: the accumulator, an auxiliary register and the control register that holds the current instruction. Each instruction carries an operand address, the address of its own successor, a function code, a 6-bit count and a vector flag. The sequencer reads or writes the operand word through a simple word-access port. It moves 5-bit characters through a paper-tape port. It charges the rotation and head-switch delays before it fetches the next instruction.

The instruction layout is, from the top bit down: operand address X in bits 31:22, successor address Y in bits 21:12, function in bits 11:7, count in bits 6:1 and vector flag in bit 0. An address is a 5-bit track (bits 9:5) and a 5-bit word position within the track (bits 4:0). When the vector flag is set, an operand instruction runs 32 times. The word position steps after each pass and wraps within the same track.

After reset the machine runs one stop instruction, fetches word 0 into the control register and waits. A pulse on the run input starts execution of that word. The block then executes instructions until it meets a stop.

Top module: `drum_seq`

## Requirements
- R1: After reset the accumulator and the auxiliary register are 0 and the control register holds 0, which is a stop. The block fetches word 0 into the control register, then waits with `halted_o` high and `running_o` low.
- R2: Bit 7 (the function LSB) is ignored, so function 17 acts as function 16. The codes 8, 10, 12, 14 and 30 and the other unlisted codes change neither register and write no memory.
- R3: Function 16 loads the operand word into A. Function 18 loads its two's complement negation. Function 20 adds it to A and function 22 subtracts it from A, both modulo 2^32. Function 24 loads the operand word into R.
- R4: Function 28 writes A to the operand word under a mask of all ones shifted right by the count field. Bits outside the mask keep their old value, and a count of 32 or more changes nothing.
- R5: Function 26 writes R in the same masked way as R4. After the write, R holds 32 copies of its former bit 31.
- R6: Function 6 takes the operand address X as the next fetch address when A bit 31 is 1. Otherwise it takes Y.
- R7: Function 2 ORs the 5-bit tape input into R bits 31:27 and raises `tape_rd_o` for one cycle. Function 4 presents R bits 31:27 on `tape_out_o` while it pulses `tape_punch_o`.
- R8: The fetch request of the next instruction comes D+3 cycles after the tape strobe or the last write of the instruction. D is the larger of the post-operation delay (32 for tape functions, 1 for stores, 0 otherwise) and the switch delay (6 when the track bits of the next address differ from those of the last accessed location, else 0).
- R9: When the vector flag is set on functions 16 to 28, the operation runs 32 times. The word position starts at that of X, increments by one after each pass and wraps modulo 32 within X's track.
- R10: Function 0 clears the running flag. The successor word is still fetched into the control register, and the block then stays halted until `run_i` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Restart pulse, taken while halted |
| mem_req_o | output | 1 | Word access request |
| mem_we_o | output | 1 | Access is a masked write |
| mem_addr_o | output | 10 | Track and word position of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_wmask_o | output | 32 | Bit mask of the write |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| tape_in_i | input | 5 | Character from the tape reader |
| tape_rd_o | output | 1 | Tape read strobe |
| tape_out_o | output | 5 | Character to the tape punch |
| tape_punch_o | output | 1 | Punch strobe |
| acc_o | output | 32 | Accumulator |
| r_o | output | 32 | Auxiliary register |
| cr_o | output | 32 | Control register (current instruction) |
| running_o | output | 1 | Running flag |
| halted_o | output | 1 | Waiting for a run pulse |

## Verification
The arithmetic functions run on random operand pairs. Each function is paired with a random second operation, so a wrong sign, a swapped operand or a lost carry shows up. Store tests use random counts from 0 to 40 over random old memory words. This tells the mask shape apart from an inverted or off-by-one mask and covers the case where nothing is written. Branches use both signs of A. Vector runs start at a word position near the end of a track, which shows whether the position wraps or carries into the track bits. Fetch gaps are measured for a tape function, a same-track store and a track-switching store, which separates the post-operation delay from the switch delay.

// File: rtl/drum_seq_pkg.sv
package drum_seq_pkg;

   localparam int FN_W = 5;

   localparam logic [FN_W-1:0] FN_STOP     = 5'd0;
   localparam logic [FN_W-1:0] FN_TAPE_IN  = 5'd2;
   localparam logic [FN_W-1:0] FN_PUNCH    = 5'd4;
   localparam logic [FN_W-1:0] FN_BRANCH   = 5'd6;
   localparam logic [FN_W-1:0] FN_LOAD_POS = 5'd16;
   localparam logic [FN_W-1:0] FN_LOAD_NEG = 5'd18;
   localparam logic [FN_W-1:0] FN_ADD      = 5'd20;
   localparam logic [FN_W-1:0] FN_SUB      = 5'd22;
   localparam logic [FN_W-1:0] FN_LOAD_R   = 5'd24;
   localparam logic [FN_W-1:0] FN_STORE_R  = 5'd26;
   localparam logic [FN_W-1:0] FN_STORE_A  = 5'd28;

   typedef enum logic [2:0] {
      ST_DEC,
      ST_OP,
      ST_OPW,
      ST_POST,
      ST_WAIT,
      ST_FETCH,
      ST_FETW,
      ST_HALT
   } seq_state_t;

   typedef struct packed {
      logic has_opnd;
      logic rd_opnd;
      logic wr_opnd;
      logic tape_in;
      logic punch;
      logic stop;
      logic branch;
   } op_class_t;

endpackage

// File: rtl/drum_seq_decode.sv
module drum_seq_decode
   import drum_seq_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 10,
   parameter int CNT_W     = 6,
   parameter int DLY_W     = 6,
   parameter int TAPE_DLY  = 32,
   parameter int STORE_DLY = 1
) (
   input  logic [DATA_W-1:0] cr,
   output logic [ADDR_W-1:0] x_addr,
   output logic [ADDR_W-1:0] y_addr,
   output logic [FN_W-1:0]   fn,
   output logic [CNT_W-1:0]  cnt,
   output logic              vec,
   output op_class_t         cls,
   output logic [DLY_W-1:0]  post_dly
);
   localparam int VEC_POS = 0;
   localparam int CNT_LO  = VEC_POS + 1;
   localparam int FN_LO   = CNT_LO + CNT_W;
   localparam int Y_LO    = FN_LO + FN_W;
   localparam int X_LO    = Y_LO + ADDR_W;

   generate
      if (X_LO + ADDR_W != DATA_W) begin : g_bad_layout
         $error("instruction fields do not fill the data word");
      end
      if (TAPE_DLY >= (1 << DLY_W) || STORE_DLY >= (1 << DLY_W)) begin : g_bad_dly
         $error("delay counter too narrow");
      end
   endgenerate

   assign x_addr = cr[X_LO +: ADDR_W];
   assign y_addr = cr[Y_LO +: ADDR_W];
   assign fn     = cr[FN_LO +: FN_W] & ~FN_W'(1);
   assign cnt    = cr[CNT_LO +: CNT_W];
   assign vec    = cr[VEC_POS];

   always_comb begin
      cls = '0;
      post_dly = '0;
      case (fn)
         FN_STOP:    cls.stop = 1'b1;
         FN_TAPE_IN: begin cls.tape_in = 1'b1; post_dly = DLY_W'(TAPE_DLY); end
         FN_PUNCH:   begin cls.punch = 1'b1; post_dly = DLY_W'(TAPE_DLY); end
         FN_BRANCH:  cls.branch = 1'b1;
         FN_LOAD_POS, FN_LOAD_NEG, FN_ADD, FN_SUB, FN_LOAD_R: begin
            cls.has_opnd = 1'b1;
            cls.rd_opnd  = 1'b1;
         end
         FN_STORE_R, FN_STORE_A: begin
            cls.has_opnd = 1'b1;
            cls.wr_opnd  = 1'b1;
            post_dly     = DLY_W'(STORE_DLY);
         end
         default: ;
      endcase
   end

   // R2: a function is never both an operand read and an operand write
   always_comb begin
      if (cls.rd_opnd) assert_cls_excl_R2: assert (!cls.wr_opnd);
   end

endmodule

// File: rtl/drum_seq_alu.sv
module drum_seq_alu
   import drum_seq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 6,
   parameter int TAPE_W = 5
) (
   input  logic [FN_W-1:0]   fn,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] rreg,
   input  logic [DATA_W-1:0] opnd,
   input  logic [TAPE_W-1:0] tape_in,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] acc_nx,
   output logic [DATA_W-1:0] r_nx,
   output logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] wmask
);
   localparam int PAD_W = DATA_W - TAPE_W;

   // mask bit i is set when i + count stays inside the word
   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         assign wmask[i] = (32'(cnt) + 32'(i)) < 32'(DATA_W);
      end
   endgenerate

   always_comb begin
      case (fn)
         FN_LOAD_POS: acc_nx = opnd;
         FN_LOAD_NEG: acc_nx = -opnd;
         FN_ADD:      acc_nx = acc + opnd;
         FN_SUB:      acc_nx = acc - opnd;
         default:     acc_nx = acc;
      endcase
   end

   always_comb begin
      case (fn)
         FN_LOAD_R:  r_nx = opnd;
         FN_STORE_R: r_nx = {DATA_W{rreg[DATA_W-1]}};
         FN_TAPE_IN: r_nx = rreg | {tape_in, {PAD_W{1'b0}}};
         default:    r_nx = rreg;
      endcase
   end

   assign wdata = (fn == FN_STORE_R) ? rreg : acc;

endmodule

// File: rtl/drum_seq_delay.sv
module drum_seq_delay #(
   parameter int TRK_W      = 5,
   parameter int DLY_W      = 6,
   parameter int SWITCH_DLY = 6,
   parameter int MAX_DLY    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DLY_W-1:0] post_dly,
   input  logic [TRK_W-1:0] cur_track,
   input  logic [TRK_W-1:0] nxt_track,
   output logic             done
);
   generate
      if (SWITCH_DLY >= (1 << DLY_W)) begin : g_bad_sw
         $error("switch delay does not fit the counter");
      end
   endgenerate

   logic [DLY_W-1:0] sw_dly;
   logic [DLY_W-1:0] charged;
   logic [DLY_W-1:0] cnt;

   assign sw_dly  = (cur_track != nxt_track) ? DLY_W'(SWITCH_DLY) : '0;
   assign charged = (post_dly > sw_dly) ? post_dly : sw_dly;
   assign done    = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= charged;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   // R8: the wait never exceeds the largest delay that can be charged
   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) <= MAX_DLY);

   // R8: a running wait counts down by one each cycle
   assert_cnt_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> !done || $past(cnt) == DLY_W'(1));

endmodule

// File: rtl/drum_seq.sv
module drum_seq
   import drum_seq_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 10,
   parameter int WORD_BITS  = 5,
   parameter int CNT_W      = 6,
   parameter int TAPE_W     = 5,
   parameter int SWITCH_DLY = 6,
   parameter int TAPE_DLY   = 32,
   parameter int STORE_DLY  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [DATA_W-1:0] mem_wmask_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   input  logic [TAPE_W-1:0] tape_in_i,
   output logic              tape_rd_o,
   output logic [TAPE_W-1:0] tape_out_o,
   output logic              tape_punch_o,
   output logic [DATA_W-1:0] acc_o,
   output logic [DATA_W-1:0] r_o,
   output logic [DATA_W-1:0] cr_o,
   output logic              running_o,
   output logic              halted_o
);
   localparam int TRK_W   = ADDR_W - WORD_BITS;
   localparam int MAX_A   = (TAPE_DLY > STORE_DLY) ? TAPE_DLY : STORE_DLY;
   localparam int MAX_DLY = (MAX_A > SWITCH_DLY) ? MAX_A : SWITCH_DLY;
   localparam int DLY_W   = $clog2(MAX_DLY + 1);

   generate
      if (WORD_BITS >= ADDR_W) begin : g_bad_addr
         $error("word position must leave room for track bits");
      end
      if (TAPE_W > DATA_W) begin : g_bad_tape
         $error("tape character wider than the word");
      end
      if ((1 << CNT_W) < DATA_W) begin : g_bad_cnt
         $error("count field cannot cover the word");
      end
   endgenerate

   seq_state_t        st;
   logic [DATA_W-1:0] acc, rreg, cr;
   logic [ADDR_W-1:0] ml;
   logic              running;
   logic [WORD_BITS-1:0] pass;

   logic [ADDR_W-1:0] x_addr, y_addr, nxt_addr;
   logic [FN_W-1:0]   fn;
   logic [CNT_W-1:0]  cnt;
   logic              vec;
   op_class_t         cls;
   logic [DLY_W-1:0]  post_dly;
   logic [DATA_W-1:0] acc_nx, r_nx, wdata, wmask;
   logic              more_pass, take_br, dly_load, dly_done;

   drum_seq_decode #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DLY_W(DLY_W),
      .TAPE_DLY(TAPE_DLY), .STORE_DLY(STORE_DLY)
   ) u_dec (
      .cr(cr), .x_addr(x_addr), .y_addr(y_addr), .fn(fn), .cnt(cnt),
      .vec(vec), .cls(cls), .post_dly(post_dly)
   );

   drum_seq_alu #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .TAPE_W(TAPE_W)
   ) u_alu (
      .fn(fn), .acc(acc), .rreg(rreg), .opnd(mem_rdata_i), .tape_in(tape_in_i),
      .cnt(cnt), .acc_nx(acc_nx), .r_nx(r_nx), .wdata(wdata), .wmask(wmask)
   );

   drum_seq_delay #(
      .TRK_W(TRK_W), .DLY_W(DLY_W), .SWITCH_DLY(SWITCH_DLY), .MAX_DLY(MAX_DLY)
   ) u_dly (
      .clk(clk), .rst_n(rst_n), .load(dly_load), .post_dly(post_dly),
      .cur_track(ml[ADDR_W-1:WORD_BITS]), .nxt_track(nxt_addr[ADDR_W-1:WORD_BITS]),
      .done(dly_done)
   );

   assign more_pass = vec && cls.has_opnd && (pass != '1);
   assign take_br   = cls.branch && acc[DATA_W-1];
   assign nxt_addr  = take_br ? x_addr : y_addr;
   assign dly_load  = (st == ST_POST) && !more_pass;

   assign mem_req_o    = (st == ST_FETCH) || ((st == ST_OP) && (cls.rd_opnd || cls.wr_opnd));
   assign mem_we_o     = (st == ST_OP) && cls.wr_opnd;
   assign mem_addr_o   = ml;
   assign mem_wdata_o  = wdata;
   assign mem_wmask_o  = wmask;
   assign tape_rd_o    = (st == ST_OP) && cls.tape_in;
   assign tape_punch_o = (st == ST_OP) && cls.punch;
   assign tape_out_o   = rreg[DATA_W-1 -: TAPE_W];
   assign acc_o        = acc;
   assign r_o          = rreg;
   assign cr_o         = cr;
   assign running_o    = running;
   assign halted_o     = (st == ST_HALT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_DEC;
         acc     <= '0;
         rreg    <= '0;
         cr      <= '0;
         ml      <= '0;
         running <= 1'b1;
         pass    <= '0;
      end else begin
         case (st)
            ST_DEC: begin
               if (cls.has_opnd) ml <= x_addr;
               pass <= '0;
               st   <= ST_OP;
            end
            ST_OP: begin
               if (cls.rd_opnd) begin
                  st <= ST_OPW;
               end else begin
                  acc  <= acc_nx;
                  rreg <= r_nx;
                  if (cls.stop) running <= 1'b0;
                  st   <= ST_POST;
               end
            end
            ST_OPW: begin
               acc  <= acc_nx;
               rreg <= r_nx;
               st   <= ST_POST;
            end
            ST_POST: begin
               if (more_pass) begin
                  ml   <= {ml[ADDR_W-1:WORD_BITS], ml[WORD_BITS-1:0] + 1'b1};
                  pass <= pass + 1'b1;
                  st   <= ST_OP;
               end else begin
                  ml <= nxt_addr;
                  st <= ST_WAIT;
               end
            end
            ST_WAIT:  if (dly_done) st <= ST_FETCH;
            ST_FETCH: st <= ST_FETW;
            ST_FETW: begin
               cr <= mem_rdata_i;
               st <= running ? ST_DEC : ST_HALT;
            end
            ST_HALT: begin
               if (run_i) begin
                  running <= 1'b1;
                  st      <= ST_DEC;
               end
            end
            default: st <= ST_HALT;
         endcase
      end
   end

   // R7: memory access and the two tape strobes never overlap
   assert_port_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req_o, tape_rd_o, tape_punch_o}));

   // R9: a further vector pass stays on the same track
   assert_vec_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POST && more_pass) |=> (st == ST_OP) && $stable(ml[ADDR_W-1:WORD_BITS]));

   // R10: a halted machine is not running and makes no access
   assert_halt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      halted_o |-> !running_o && !mem_req_o);

   // R5: after a register store, R is all zeros or all ones
   assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && fn == FN_STORE_R) |=> (rreg == '0 || rreg == '1));

   // R4: writes only come from store functions
   assert_we_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> mem_req_o && (fn == FN_STORE_A || fn == FN_STORE_R));

endmodule

// File: tb/drum_seq_test.sv
module drum_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_i = 1'b0;
   logic        mem_req_o, mem_we_o;
   logic [9:0]  mem_addr_o;
   logic [31:0] mem_wdata_o, mem_wmask_o, mem_rdata_i;
   logic [4:0]  tape_in_i = 5'd0;
   logic        tape_rd_o, tape_punch_o;
   logic [4:0]  tape_out_o;
   logic [31:0] acc_o, r_o, cr_o;
   logic        running_o, halted_o;

   always #2 clk = ~clk;

   drum_seq uut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_wmask_o(mem_wmask_o), .mem_rdata_i(mem_rdata_i),
      .tape_in_i(tape_in_i), .tape_rd_o(tape_rd_o), .tape_out_o(tape_out_o),
      .tape_punch_o(tape_punch_o), .acc_o(acc_o), .r_o(r_o), .cr_o(cr_o),
      .running_o(running_o), .halted_o(halted_o)
   );

   // drum model: one memory process, preload port used only while idle
   logic [31:0] mem [0:1023];
   logic        pk_en = 1'b0;
   logic [9:0]  pk_a = '0;
   logic [31:0] pk_d = '0;

   always @(posedge clk) begin
      if (pk_en)
         mem[pk_a] <= pk_d;
      else if (mem_req_o) begin
         if (mem_we_o)
            mem[mem_addr_o] <= (mem[mem_addr_o] & ~mem_wmask_o) | (mem_wdata_o & mem_wmask_o);
         else
            mem_rdata_i <= mem[mem_addr_o];
      end
   end

   // monitor: cycle count, punch capture, fetch gap after tape or write
   int          cyc = 0;
   int          mark = 0;
   bit          armed = 0;
   int          gap = -1;
   logic [4:0]  punch_val = '0;
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (tape_punch_o) punch_val <= tape_out_o;
      if (tape_punch_o || tape_rd_o || (mem_req_o && mem_we_o)) begin
         mark  <= cyc;
         armed <= 1'b1;
      end else if (armed && mem_req_o && !mem_we_o) begin
         gap   <= cyc - mark;
         armed <= 1'b0;
      end
   end

   int total = 0;
   int bad = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic logic [31:0] ins(input int x, input int y, input int fn,
                                       input int c, input int v);
      logic [9:0] xa = x[9:0];
      logic [9:0] ya = y[9:0];
      return {xa, ya, fn[4:0], c[5:0], v[0]};
   endfunction

   function automatic logic [31:0] mk_mask(input int c);
      return (c >= 32) ? 32'd0 : (32'hFFFF_FFFF >> c);
   endfunction

   function automatic logic [31:0] exp_acc(input int fn, input logic [31:0] a,
                                           input logic [31:0] op);
      case (fn)
         16: return op;
         18: return -op;
         20: return a + op;
         22: return a - op;
         default: return a;
      endcase
   endfunction

   task automatic poke(input int a, input logic [31:0] d);
      @(negedge clk);
      pk_en = 1'b1; pk_a = a[9:0]; pk_d = d;
      @(negedge clk);
      pk_en = 1'b0;
   endtask

   task automatic wait_halt();
      int n = 0;
      while (!halted_o && n < 3000) begin
         @(negedge clk);
         n++;
      end
      if (!halted_o) begin
         total++;
         bad++;
         $display("FAIL halt actual=busy expected=halted");
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_halt();
   endtask

   task automatic run_prog();
      do_reset();
      @(negedge clk); run_i = 1'b1;
      @(negedge clk); run_i = 1'b0;
      wait_halt();
   endtask

   initial begin
      logic [31:0] v0, v1, v2, mk, expw, sum;
      int fnsel, c;
      void'($urandom(32'd4711));
      for (int i = 0; i < 1024; i++) mem[i] = 32'd0;

      // R1: reset state and reset fetch of word 0
      poke(0, 32'h1234_5670);
      do_reset();
      check("R1 cr after reset fetch", cr_o, 32'h1234_5670);
      check("R1 acc zero", acc_o, 32'd0);
      check("R1 r zero", r_o, 32'd0);
      check("R1 running low", {31'd0, running_o}, 32'd0);

      // R3: arithmetic and register loads on random operands
      for (int k = 0; k < 12; k++) begin
         int fns[5] = '{16, 18, 20, 22, 24};
         v0 = $urandom(); v1 = $urandom();
         fnsel = fns[$urandom_range(0, 4)];
         poke(300, v0); poke(301, v1);
         poke(0, ins(300, 1, 16, 0, 0));
         poke(1, ins(301, 2, fnsel, 0, 0));
         poke(2, ins(0, 3, 0, 0, 0));
         poke(3, 32'hCAFE_0003);
         run_prog();
         check("R3 acc", acc_o, exp_acc(fnsel, v0, v1));
         check("R3 r", r_o, (fnsel == 24) ? v1 : 32'd0);
         check("R10 cr holds successor", cr_o, 32'hCAFE_0003);
      end

      // R4: masked store of A, random count, track switch delay
      for (int k = 0; k < 8; k++) begin
         v0 = $urandom(); v1 = $urandom();
         c = (k == 0) ? 0 : (k == 1) ? 32 : $urandom_range(0, 40);
         poke(300, v0); poke(301, v1);
         poke(0, ins(300, 1, 16, 0, 0));
         poke(1, ins(301, 2, 28, c, 0));
         poke(2, ins(0, 3, 0, 0, 0));
         run_prog();
         mk = mk_mask(c);
         check("R4 stored word", mem[301], (v1 & ~mk) | (v0 & mk));
         check("R8 gap store with track switch", gap, 9);
      end

      // R5: masked store of R and sign fill
      for (int k = 0; k < 6; k++) begin
         v0 = $urandom(); v1 = $urandom();
         if (k == 0) v0[31] = 1'b1;
         if (k == 1) v0[31] = 1'b0;
         c = $urandom_range(0, 35);
         poke(300, v0); poke(301, v1);
         poke(0, ins(300, 1, 24, 0, 0));
         poke(1, ins(301, 2, 26, c, 0));
         poke(2, ins(0, 3, 0, 0, 0));
         run_prog();
         mk = mk_mask(c);
         check("R5 stored word", mem[301], (v1 & ~mk) | (v0 & mk));
         check("R5 sign fill", r_o, {32{v0[31]}});
      end

      // R8: same-track store charges only the store delay
      poke(300, 32'h0BAD_F00D); poke(20, 32'hFFFF_0000);
      poke(0, ins(300, 1, 16, 0, 0));
      poke(1, ins(20, 2, 28, 0, 0));
      poke(2, ins(0, 3, 0, 0, 0));
      run_prog();
      check("R8 gap store same track", gap, 4);
      check("R4 full mask store", mem[20], 32'h0BAD_F00D);

      // R6: branch on accumulator sign, both ways
      for (int k = 0; k < 4; k++) begin
         v0 = $urandom();
         v0[31] = k[0];
         v1 = $urandom(); v2 = $urandom();
         poke(300, v0); poke(310, v1); poke(311, v2);
         poke(0, ins(300, 1, 16, 0, 0));
         poke(1, ins(10, 20, 6, 0, 0));
         poke(10, ins(310, 11, 16, 0, 0));
         poke(11, ins(0, 3, 0, 0, 0));
         poke(20, ins(311, 21, 16, 0, 0));
         poke(21, ins(0, 3, 0, 0, 0));
         run_prog();
         check("R6 branch target", acc_o, v0[31] ? v1 : v2);
      end

      // R7: tape read OR and punch; R8 tape delay
      for (int k = 0; k < 4; k++) begin
         v0 = $urandom();
         tape_in_i = 5'($urandom());
         poke(300, v0);
         poke(0, ins(300, 1, 24, 0, 0));
         poke(1, ins(0, 2, 2, 0, 0));
         poke(2, ins(0, 3, 4, 0, 0));
         poke(3, ins(0, 4, 0, 0, 0));
         run_prog();
         v1 = v0 | {tape_in_i, 27'd0};
         check("R7 tape read or", r_o, v1);
         check("R7 punch value", {27'd0, punch_val}, {27'd0, v1[31:27]});
         check("R8 gap after punch", gap, 35);
      end

      // R2: function LSB ignored; unlisted functions have no effect
      v0 = $urandom(); v1 = $urandom(); v2 = $urandom();
      poke(300, v0); poke(301, v1); poke(302, v2);
      poke(0, ins(300, 1, 17, 0, 0));
      poke(1, ins(302, 2, 24, 0, 0));
      poke(2, ins(301, 3, 8, 5, 0));
      poke(3, ins(301, 4, 12, 0, 1));
      poke(4, ins(301, 5, 30, 0, 0));
      poke(5, ins(0, 6, 0, 0, 0));
      run_prog();
      check("R2 odd function code", acc_o, v0);
      check("R2 unlisted keeps r", r_o, v2);
      check("R2 unlisted keeps memory", mem[301], v1);

      // R9: vector add wraps word position within track 12
      sum = 32'd0;
      for (int i = 0; i < 32; i++) begin
         v0 = $urandom();
         poke(384 + i, v0);
         sum = sum + v0;
      end
      poke(0, ins(391, 1, 20, 0, 1));
      poke(1, ins(0, 2, 0, 0, 0));
      run_prog();
      check("R9 vector sum", acc_o, sum);

      // R9: vector store fills a whole track
      v0 = $urandom();
      poke(300, v0);
      poke(0, ins(300, 1, 16, 0, 0));
      poke(1, ins(419, 2, 28, 0, 1));
      poke(2, ins(0, 3, 0, 0, 0));
      run_prog();
      expw = 32'd0;
      for (int i = 0; i < 32; i++)
         if (mem[416 + i] !== v0) expw = expw + 1;
      check("R9 vector store words wrong", expw, 32'd0);
      check("R9 next track untouched", mem[448], 32'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule